// File: doc/BRIEF.md
# Lockstep SIMD Processing-Element Array

A row of identical processing elements that all decode one shared instruction in the same clock cycle. Each element keeps an accumulator, a second-operand register, a routing register, a scratch register, an index register and an enable flag. An element whose flag is clear sits out the instruction, so data-dependent control flow is expressed by switching elements off rather than by issuing different operations to them. A 64-bit operand from the control side reaches every element at once, and each element has its own read data port from its local memory.

Arithmetic works on a 64-bit word that can be split into one 64-bit lane, two 32-bit lanes or eight 8-bit lanes. Each lane wraps on its own width, and no carry or borrow crosses a lane edge. The routing registers form a ring, so a single instruction shifts every routing value one place up or down. Each element drives its memory address (the instruction address field plus its index register, modulo the memory depth), its write data and its write strobe.

Top module: `simd_pe_array`

## Requirements
- R1: After reset every enable flag reads 1 on `mode_vec` and every element register is zero. Storing A gives write data 0, and `mem_addr` equals `op_addr`.
- R2: `op_code` 4 loads A from `bcast_data`, 5 loads B from it, 1 loads A from the element's read data, 2 loads B from it and 3 loads X from its low 11 bits. All active elements do this in the same cycle. With `op_code` 15 (store A) or 16 (store R), each element drives that register on its `mem_wdata` slice in the same cycle and raises `mem_we` exactly when it is active.
- R3: `op_code` 6 sets A to A+B lane by lane. `lane_sel` 0 gives one 64-bit lane, 1 gives two 32-bit lanes (bits 31:0 and 63:32), and 2 gives eight 8-bit lanes. A carry out of a lane is dropped.
- R4: `op_code` 7 sets A to A−B lane by lane with the same lane choices. A borrow does not reach the next lane.
- R5: `op_code` 8, 9 and 10 set A to A AND B, A OR B and A XOR B bitwise, whatever `lane_sel` holds.
- R6: An element whose flag is 0 leaves A, B, R, S, X and its flag (except under R7) unchanged, and keeps `mem_we` low.
- R7: `op_code` 17 loads every element's flag from bit 0 of its own A, including inactive elements. `op_code` 18 sets every flag to 1.
- R8: `mem_addr` of element i is (`op_addr` + X of element i) mod 2048, combinational in the same cycle.
- R9: `op_code` 20 loads R of element i with the old R of element (i−1) mod N, and 21 with the old R of element (i+1) mod N. Inactive elements still supply their R to their neighbours but keep their own.
- R10: `op_code` 11 copies A to R, 12 copies R to A, 13 copies A to S and 14 copies S to A. Code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_code | input | 5 | Broadcast opcode |
| lane_sel | input | 2 | Lane split: 0 = 64, 1 = 2×32, 2 = 8×8 |
| op_addr | input | 11 | Instruction address field |
| bcast_data | input | 64 | Operand broadcast to all elements |
| mem_rdata | input | N×64 | Local-memory read data, element i in bits [64i+63:64i] |
| mem_addr | output | N×11 | Per-element memory address |
| mem_wdata | output | N×64 | Per-element memory write data |
| mem_we | output | N | Per-element write strobe |
| mode_vec | output | N | Per-element enable flags |

## Verification
Register results (loads, lane arithmetic, moves, routing, flag changes) take effect at the first rising edge after the instruction is presented. The bench drives each instruction on a falling edge and reads the effect back half a cycle after the next rising edge, usually by presenting a store and sampling the combinational write data. Addresses, write data and strobes follow the inputs within the same cycle, so they are sampled one time step after the drive, before any edge. Reset is released on a falling edge, and two extra edges are allowed for the internal synchronizer before the first instruction.

// File: rtl/simd_pe_pkg.sv
package simd_pe_pkg;
  typedef enum logic [4:0] {
    OP_NOP       = 5'd0,
    OP_LDA_M     = 5'd1,
    OP_LDB_M     = 5'd2,
    OP_LDX_M     = 5'd3,
    OP_LDA_C     = 5'd4,
    OP_LDB_C     = 5'd5,
    OP_ADD       = 5'd6,
    OP_SUB       = 5'd7,
    OP_AND       = 5'd8,
    OP_OR        = 5'd9,
    OP_XOR       = 5'd10,
    OP_A2R       = 5'd11,
    OP_R2A       = 5'd12,
    OP_A2S       = 5'd13,
    OP_S2A       = 5'd14,
    OP_STA       = 5'd15,
    OP_STR       = 5'd16,
    OP_MODE_A    = 5'd17,
    OP_MODE_ALL  = 5'd18,
    OP_RSV       = 5'd19,
    OP_ROUTE_FWD = 5'd20,
    OP_ROUTE_BWD = 5'd21
  } pe_op_e;

  typedef enum logic [1:0] {
    LANE_64 = 2'd0,
    LANE_32 = 2'd1,
    LANE_8  = 2'd2,
    LANE_XX = 2'd3
  } lane_e;
endpackage

// File: rtl/pe_lane_alu.sv
module pe_lane_alu
  import simd_pe_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  lane_e        lane_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  localparam int NB   = W / 8;
  localparam int HALF = NB / 2;

  logic [NB-1:0] cin;
  logic [NB-1:0] cout;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [7:0] b_eff;
    logic       lane_edge;
    if (k == 0) begin : g_first
      assign lane_edge = 1'b1;
    end else if (k == HALF) begin : g_half
      assign lane_edge = (lane_i == LANE_8) || (lane_i == LANE_32);
    end else begin : g_mid
      assign lane_edge = (lane_i == LANE_8);
    end
    if (k == 0) begin : g_c0
      assign cin[k] = sub_i;
    end else begin : g_cn
      assign cin[k] = lane_edge ? sub_i : cout[k-1];
    end
    assign b_eff = sub_i ? ~b_i[k*8 +: 8] : b_i[k*8 +: 8];
    assign {cout[k], sum_o[k*8 +: 8]} =
      {1'b0, a_i[k*8 +: 8]} + {1'b0, b_eff} + {8'd0, cin[k]};
  end
endmodule

// File: rtl/pe_element.sv
module pe_element
  import simd_pe_pkg::*;
#(
  parameter int W  = 64,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pe_op_e        op_i,
  input  lane_e         lane_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  bcast_i,
  input  logic [W-1:0]  rdata_i,
  input  logic [W-1:0]  prev_r_i,
  input  logic [W-1:0]  next_r_i,
  output logic [W-1:0]  r_o,
  output logic          mode_o,
  output logic [AW-1:0] maddr_o,
  output logic [W-1:0]  wdata_o,
  output logic          we_o
);
  logic [W-1:0]  acc_q, acc_d, opb_q, opb_d, rte_q, rte_d, scr_q, scr_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          mode_q, mode_d;
  logic [W-1:0]  alu_sum;
  logic          reg_en;

  pe_lane_alu #(.W(W)) u_alu (
    .a_i   (acc_q),
    .b_i   (opb_q),
    .lane_i(lane_i),
    .sub_i (op_i == OP_SUB),
    .sum_o (alu_sum)
  );

  assign reg_en = mode_q;

  always_comb begin
    acc_d  = acc_q;
    opb_d  = opb_q;
    rte_d  = rte_q;
    scr_d  = scr_q;
    idx_d  = idx_q;
    mode_d = mode_q;
    if (reg_en) begin
      case (op_i)
        OP_LDA_M:              acc_d = rdata_i;
        OP_LDB_M:              opb_d = rdata_i;
        OP_LDX_M:              idx_d = rdata_i[AW-1:0];
        OP_LDA_C:              acc_d = bcast_i;
        OP_LDB_C:              opb_d = bcast_i;
        OP_ADD, OP_SUB:        acc_d = alu_sum;
        OP_AND:                acc_d = acc_q & opb_q;
        OP_OR:                 acc_d = acc_q | opb_q;
        OP_XOR:                acc_d = acc_q ^ opb_q;
        OP_A2R:                rte_d = acc_q;
        OP_R2A:                acc_d = rte_q;
        OP_A2S:                scr_d = acc_q;
        OP_S2A:                acc_d = scr_q;
        OP_ROUTE_FWD, OP_ROUTE_BWD:
                               rte_d = op_i[0] ? next_r_i : prev_r_i;
        default: ;
      endcase
    end
    case (op_i)
      OP_MODE_A:   mode_d = acc_q[0];
      OP_MODE_ALL: mode_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      opb_q  <= '0;
      rte_q  <= '0;
      scr_q  <= '0;
      idx_q  <= '0;
      mode_q <= 1'b1;
    end else begin
      acc_q  <= acc_d;
      opb_q  <= opb_d;
      rte_q  <= rte_d;
      scr_q  <= scr_d;
      idx_q  <= idx_d;
      mode_q <= mode_d;
    end
  end

  assign r_o     = rte_q;
  assign mode_o  = mode_q;
  assign maddr_o = addr_i + idx_q;
  assign wdata_o = (op_i == OP_STR) ? rte_q : acc_q;
  assign we_o    = mode_q && ((op_i == OP_STA) || (op_i == OP_STR));

  // R6
  inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |=> ($stable(acc_q) && $stable(opb_q) && $stable(rte_q)
                 && $stable(scr_q) && $stable(idx_q)));

  // R9
  route_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && op_i == OP_ROUTE_FWD) |=> (rte_q == $past(prev_r_i)));

  // R7
  mode_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MODE_ALL) |=> mode_q);

  // R3
  lane8_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && op_i == OP_ADD && lane_i == LANE_8)
      |=> (acc_q[7:0] == $past(8'(acc_q[7:0] + opb_q[7:0]))));
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pe_pkg::*;
#(
  parameter int N  = 64,
  parameter int W  = 64,
  parameter int AW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      op_code,
  input  logic [1:0]      lane_sel,
  input  logic [AW-1:0]   op_addr,
  input  logic [W-1:0]    bcast_data,
  input  logic [N*W-1:0]  mem_rdata,
  output logic [N*AW-1:0] mem_addr,
  output logic [N*W-1:0]  mem_wdata,
  output logic [N-1:0]    mem_we,
  output logic [N-1:0]    mode_vec
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  pe_op_e     op;
  lane_e      lane;
  logic [W-1:0] r_ring [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign op   = pe_op_e'(op_code);
  assign lane = lane_e'(lane_sel);

  for (genvar g = 0; g < N; g++) begin : g_pe
    localparam int PREV = (g + N - 1) % N;
    localparam int NEXT = (g + 1) % N;
    pe_element #(.W(W), .AW(AW)) u_pe (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .op_i    (op),
      .lane_i  (lane),
      .addr_i  (op_addr),
      .bcast_i (bcast_data),
      .rdata_i (mem_rdata[g*W +: W]),
      .prev_r_i(r_ring[PREV]),
      .next_r_i(r_ring[NEXT]),
      .r_o     (r_ring[g]),
      .mode_o  (mode_vec[g]),
      .maddr_o (mem_addr[g*AW +: AW]),
      .wdata_o (mem_wdata[g*W +: W]),
      .we_o    (mem_we[g])
    );
  end
endmodule

// File: tb/simd_pe_array_tb.sv
module simd_pe_array_tb_top;
  import simd_pe_pkg::*;

  localparam int N = 64;
  localparam int W = 64;
  localparam int AW = 11;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [4:0]   op;
    logic [1:0]   lane;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{5'd6,  2'd0, 64'hFFFFFFFFFFFFFFFF, 64'h1, 64'h0},                      // R3
    '{5'd6,  2'd1, 64'h00000000FFFFFFFF, 64'h1, 64'h0},                      // R3
    '{5'd6,  2'd2, 64'h00FF00FF00FF00FF, 64'h0101010101010101, 64'h0100010001000100},
    '{5'd6,  2'd1, 64'h7FFFFFFF80000000, 64'h0000000180000000, 64'h8000000000000000},
    '{5'd7,  2'd2, 64'h0, 64'h0101010101010101, 64'hFFFFFFFFFFFFFFFF},       // R4
    '{5'd7,  2'd1, 64'h0000000100000000, 64'h1, 64'h00000001FFFFFFFF},
    '{5'd7,  2'd0, 64'h0000000100000000, 64'h1, 64'h00000000FFFFFFFF},
    '{5'd8,  2'd2, 64'hF0F0F0F0F0F0F0F0, 64'hFF00FF00FF00FF00, 64'hF000F000F000F000}, // R5
    '{5'd9,  2'd1, 64'hF0F0F0F0F0F0F0F0, 64'hFF00FF00FF00FF00, 64'hFFF0FFF0FFF0FFF0},
    '{5'd10, 2'd0, 64'hF0F0F0F0F0F0F0F0, 64'hFF00FF00FF00FF00, 64'h0FF00FF00FF00FF0}
  };

  logic            clk;
  logic            rst_n;
  logic [4:0]      op_code;
  logic [1:0]      lane_sel;
  logic [AW-1:0]   op_addr;
  logic [W-1:0]    bcast_data;
  logic [N*W-1:0]  mem_rdata;
  logic [N*AW-1:0] mem_addr;
  logic [N*W-1:0]  mem_wdata;
  logic [N-1:0]    mem_we;
  logic [N-1:0]    mode_vec;
  logic [W-1:0]    rd [N];
  logic [W-1:0]    ref_v [N];
  logic [N-1:0]    act;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  simd_pe_array #(.N(N), .W(W), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .lane_sel(lane_sel),
    .op_addr(op_addr), .bcast_data(bcast_data), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mode_vec(mode_vec)
  );

  always_comb for (int i = 0; i < N; i++) mem_rdata[i*W +: W] = rd[i];

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [W-1:0] lane_model(logic [4:0] op, logic [1:0] ln,
                                                logic [W-1:0] a, logic [W-1:0] b);
    int lw;
    logic [W-1:0] r, m, x, y;
    if (op == 5'd8) return a & b;
    if (op == 5'd9) return a | b;
    if (op == 5'd10) return a ^ b;
    lw = (ln == 2'd1) ? 32 : (ln == 2'd2) ? 8 : 64;
    m = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    r = '0;
    for (int l = 0; l < 64 / lw; l++) begin
      x = (a >> (l * lw)) & m;
      y = (b >> (l * lw)) & m;
      r = r | ((((op == 5'd7) ? (x - y) : (x + y)) & m) << (l * lw));
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] actual, logic [W-1:0] expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic issue(logic [4:0] op, logic [1:0] ln = 2'd0, logic [W-1:0] bc = '0);
    op_code = op; lane_sel = ln; bcast_data = bc;
    @(posedge clk);
    @(negedge clk);
    op_code = 5'd0;
  endtask

  // present a store in the current cycle and compare every slice against ref_v
  task automatic check_store(logic [4:0] st, string req, logic [N-1:0] exp_we);
    op_code = st;
    #1;
    for (int i = 0; i < N; i++) begin
      chk(mem_wdata[i*W +: W] == ref_v[i], req, mem_wdata[i*W +: W], ref_v[i]);
      chk(mem_we[i] == exp_we[i], req, W'(mem_we[i]), W'(exp_we[i]));
    end
    @(posedge clk);
    @(negedge clk);
    op_code = 5'd0;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; op_code = '0; lane_sel = '0; op_addr = '0; bcast_data = '0;
    for (int i = 0; i < N; i++) rd[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(mode_vec == '1, "R1", W'(mode_vec), W'({N{1'b1}}));
    op_addr = 11'd5;
    #1;
    for (int i = 0; i < N; i++)
      chk(mem_addr[i*AW +: AW] == 11'd5, "R1", W'(mem_addr[i*AW +: AW]), 64'd5);
    for (int i = 0; i < N; i++) ref_v[i] = '0;
    check_store(5'd15, "R1", '1);
    check_store(5'd16, "R1", '1);

    // R3 R4 R5 table walk (broadcast loads, R2)
    for (int v = 0; v < NV; v++) begin
      chk(lane_model(TBL[v].op, TBL[v].lane, TBL[v].a, TBL[v].b) == TBL[v].exp,
          "R3 model", lane_model(TBL[v].op, TBL[v].lane, TBL[v].a, TBL[v].b), TBL[v].exp);
      issue(5'd4, 2'd0, TBL[v].a);
      issue(5'd5, 2'd0, TBL[v].b);
      issue(TBL[v].op, TBL[v].lane);
      for (int i = 0; i < N; i++) ref_v[i] = TBL[v].exp;
      check_store(5'd15, (TBL[v].op == 5'd6) ? "R3" : (TBL[v].op == 5'd7) ? "R4" : "R5", '1);
    end

    // R2 R3 per-element data from memory, lane 8 add
    for (int i = 0; i < N; i++) rd[i] = 64'h0F1E2D3C4B5A6978 * 64'(i + 1);
    issue(5'd1);
    issue(5'd5, 2'd0, 64'h80FF7F0180FF7F01);
    issue(5'd6, 2'd2);
    for (int i = 0; i < N; i++) ref_v[i] = lane_model(5'd6, 2'd2, rd[i], 64'h80FF7F0180FF7F01);
    check_store(5'd15, "R3", '1);
    // R4 lane 32 subtract from memory B
    issue(5'd1);
    for (int i = 0; i < N; i++) rd[i] = ~rd[i] + 64'(i);
    issue(5'd2);
    issue(5'd7, 2'd1);
    for (int i = 0; i < N; i++)
      ref_v[i] = lane_model(5'd7, 2'd1, 64'h0F1E2D3C4B5A6978 * 64'(i + 1), rd[i]);
    check_store(5'd15, "R4", '1);

    // R10 moves among A, R, S
    for (int i = 0; i < N; i++) rd[i] = 64'hA5A5000000000000 | 64'(i * 7);
    issue(5'd1);
    issue(5'd11);
    issue(5'd13);
    issue(5'd4, 2'd0, 64'h0);
    issue(5'd0);
    for (int i = 0; i < N; i++) ref_v[i] = '0;
    check_store(5'd15, "R10 nop", '1);
    for (int i = 0; i < N; i++) ref_v[i] = rd[i];
    check_store(5'd16, "R10 a2r", '1);
    issue(5'd14);
    check_store(5'd15, "R10 s2a", '1);
    issue(5'd4, 2'd0, 64'h1234);
    issue(5'd12);
    check_store(5'd15, "R10 r2a", '1);

    // R8 address = op_addr + X mod 2048
    for (int i = 0; i < N; i++) rd[i] = 64'hFFFF000000000000 | 64'(2040 + i);
    issue(5'd3);
    op_addr = 11'd10;
    #1;
    for (int i = 0; i < N; i++)
      chk(mem_addr[i*AW +: AW] == 11'((2050 + i) % 2048), "R8",
          W'(mem_addr[i*AW +: AW]), W'((2050 + i) % 2048));
    @(negedge clk);

    // R9 ring route both directions
    for (int i = 0; i < N; i++) rd[i] = 64'(i * 3 + 1);
    issue(5'd1);
    issue(5'd11);
    issue(5'd20);
    for (int i = 0; i < N; i++) ref_v[i] = rd[(i + N - 1) % N];
    check_store(5'd16, "R9 fwd", '1);
    issue(5'd21);
    for (int i = 0; i < N; i++) ref_v[i] = rd[i];
    check_store(5'd16, "R9 bwd", '1);

    // R6 R7 data-dependent enable
    for (int i = 0; i < N; i++) begin
      act[i] = (i % 3) != 0;
      rd[i] = (64'(i) << 8) | 64'(act[i]);
    end
    issue(5'd1);
    issue(5'd11);
    issue(5'd17);
    chk(mode_vec == act, "R7", W'(mode_vec), W'(act));
    issue(5'd4, 2'd0, 64'hDEAD0000BEEF0001);
    for (int i = 0; i < N; i++) ref_v[i] = act[i] ? 64'hDEAD0000BEEF0001 : rd[i];
    check_store(5'd15, "R6", act);
    issue(5'd20);
    for (int i = 0; i < N; i++) ref_v[i] = act[i] ? rd[(i + N - 1) % N] : rd[i];
    check_store(5'd16, "R9 inactive", act);
    issue(5'd18);
    chk(mode_vec == '1, "R7", W'(mode_vec), W'({N{1'b1}}));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule